// File: doc/BRIEF.md
# Sign-Selectable Two-Stage 16-bit Multiplier

This block multiplies two 16-bit operands and returns a 32-bit product. Each operand comes with its own flag that marks it as signed or unsigned. With those flags, software can build wider signed or unsigned products out of 16-bit partial products, because the upper and lower halves of a wide operand can be treated differently.

The block has two register stages. The first stage, which plays the role of the first execute stage, captures the operands and widens them to 17 bits. The second stage forms the product and registers it. As a result, the multiplier array sits in a stage of its own and stays out of the path that feeds operands into the first stage. A new operation may be issued on every cycle. The output valid travels one cycle behind the captured operands, so a dependent operation sees the product one cycle after the operands were captured.

The multiplier array can be built in one of two ways, chosen by a parameter. One is an inferred signed multiply. The other is an explicit shift-and-add array of partial products. Both give the same result.

Top module: `smul16_top`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `product` is 0 until the first accepted operation reaches the output.
- R2: With both sign flags at 0 (unsigned), `product` equals the unsigned product of `op_a` and `op_b`. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R3: With both sign flags at 1 (two's complement), `product` equals the signed product of the two operands, written as a 32-bit two's complement value. For example, 0x8000 times 0x8000 gives 0x40000000.
- R4: With mixed flags (`a_signed`=1 and `b_signed`=0, or the reverse), the signed operand is sign-extended to 17 bits and the unsigned operand is zero-extended to 17 bits. `product` is the low 32 bits of their product. For example, a signed 0xFFFF times an unsigned 0xFFFF gives 0xFFFF0001.
- R5: An operation presented with `in_valid`=1 at clock edge N appears at the output after edge N+1. At that point `out_valid`=1 for exactly one cycle for each accepted operation.
- R6: Operations presented on consecutive cycles each produce their own correct product on consecutive cycles, in the order they were issued.
- R7: When `in_valid` is 0, the values on the operand and sign inputs have no effect. `product` keeps the last result it produced, and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| in_valid | input | 1 | Operation request |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| a_signed | input | 1 | 1: op_a is two's complement, 0: unsigned |
| b_signed | input | 1 | 1: op_b is two's complement, 0: unsigned |
| out_valid | output | 1 | Product valid |
| product | output | 32 | Low 32 bits of the 17x17 product |

## Verification
The hardest case to reach from the ports is a stream of operations issued back to back, where the sign flags change from one cycle to the next. In that case the first-stage register is overwritten with a new signedness in the same edge that the second stage consumes the previous one. The stimulus issues a run of eight consecutive operations. The run cycles through all four flag combinations and uses extreme operand values such as 0x8000 and 0xFFFF. Each result is checked against a queue of expected values that trails the issue point by the pipeline depth. A separate idle test changes the operands and flags while `in_valid` is low, then confirms that the held product does not move.

// File: rtl/smul16_pkg.sv
package smul16_pkg;
  typedef enum logic [0:0] {
    MUL_INFER = 1'b0,
    MUL_ARRAY = 1'b1
  } mul_arch_e;

  function automatic logic extend_msb(input logic msb, input logic is_signed);
    return msb & is_signed;
  endfunction
endpackage

// File: rtl/smul16_rst_sync.sv
module smul16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/smul16_opnd_stage.sv
module smul16_opnd_stage
  import smul16_pkg::*;
#(
  parameter int OP_W  = 16,
  localparam int EXT_W = OP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [OP_W-1:0]         op_a,
  input  logic [OP_W-1:0]         op_b,
  input  logic                    a_signed,
  input  logic                    b_signed,
  output logic                    s1_valid,
  output logic signed [EXT_W-1:0] s1_a,
  output logic signed [EXT_W-1:0] s1_b
);
  logic                    valid_d;
  logic signed [EXT_W-1:0] a_d;
  logic signed [EXT_W-1:0] b_d;
  logic                    opnd_en;

  // next state: widen each operand according to its own flag
  always_comb begin
    opnd_en = in_valid;
    valid_d = in_valid;
    a_d     = {extend_msb(op_a[OP_W-1], a_signed), op_a};
    b_d     = {extend_msb(op_b[OP_W-1], b_signed), op_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= valid_d;
      if (opnd_en) begin
        s1_a <= a_d;
        s1_b <= b_d;
      end
    end
  end

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  p_zext_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_signed) |=> (s1_a[EXT_W-1] == 1'b0));

  p_sext_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && b_signed) |=> (s1_b[EXT_W-1] == s1_b[EXT_W-2]));
endmodule

// File: rtl/smul16_prod_stage.sv
module smul16_prod_stage
  import smul16_pkg::*;
#(
  parameter int        OP_W = 16,
  parameter mul_arch_e ARCH = MUL_INFER,
  localparam int EXT_W  = OP_W + 1,
  localparam int FULL_W = 2 * EXT_W,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic signed [EXT_W-1:0] s1_a,
  input  logic signed [EXT_W-1:0] s1_b,
  output logic                    out_valid,
  output logic [PROD_W-1:0]       product
);
  logic [FULL_W-1:0] full_prod;
  logic [PROD_W-1:0] prod_d;
  logic              prod_en;

  generate
    if (ARCH == MUL_INFER) begin : g_infer
      always_comb begin
        full_prod = FULL_W'(FULL_W'(s1_a) * FULL_W'(s1_b));
      end
    end else begin : g_array
      // two's complement partial products; the top multiplier bit has negative weight
      logic [FULL_W-1:0] a_wide;
      always_comb begin
        a_wide    = FULL_W'(s1_a);
        full_prod = '0;
        for (int i = 0; i < EXT_W; i++) begin
          if (s1_b[i]) begin
            if (i == EXT_W - 1) full_prod = full_prod - (a_wide << i);
            else                full_prod = full_prod + (a_wide << i);
          end
        end
      end
    end
  endgenerate

  always_comb begin
    prod_en = s1_valid;
    prod_d  = full_prod[PROD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (prod_en) product <= prod_d;
    end
  end

  p_out_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  p_out_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(product));
endmodule

// File: rtl/smul16_top.sv
module smul16_top
  import smul16_pkg::*;
#(
  parameter int        OP_W       = 16,
  parameter mul_arch_e ARCH       = MUL_INFER,
  parameter int        RST_STAGES = 2,
  localparam int EXT_W  = OP_W + 1,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              a_signed,
  input  logic              b_signed,
  output logic              out_valid,
  output logic [PROD_W-1:0] product
);
  logic                    rst_n_int;
  logic                    s1_valid;
  logic signed [EXT_W-1:0] s1_a;
  logic signed [EXT_W-1:0] s1_b;

  smul16_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  smul16_opnd_stage #(.OP_W(OP_W)) opnd_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .a_signed (a_signed),
    .b_signed (b_signed),
    .s1_valid (s1_valid),
    .s1_a     (s1_a),
    .s1_b     (s1_b)
  );

  smul16_prod_stage #(.OP_W(OP_W), .ARCH(ARCH)) prod_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .s1_valid  (s1_valid),
    .s1_a      (s1_a),
    .s1_b      (s1_b),
    .out_valid (out_valid),
    .product   (product)
  );

  p_no_valid_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> !out_valid);
endmodule

// File: tb/smul16_tb.sv
module smul16_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic        a_signed;
  logic        b_signed;
  logic        out_valid;
  logic [31:0] product;

  int checks;
  int fails;

  smul16_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .out_valid(out_valid), .product(product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic sa, input logic sb);
    logic signed [33:0] ea;
    logic signed [33:0] eb;
    logic signed [33:0] p;
    ea = sa ? 34'(signed'(a)) : 34'({18'd0, a});
    eb = sb ? 34'(signed'(b)) : 34'({18'd0, b});
    p  = ea * eb;
    return p[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                       input logic sa, input logic sb);
    in_valid = v; op_a = a; op_b = b; a_signed = sa; b_signed = sb;
  endtask

  // issue at a negedge, result visible two negedges later
  task automatic one_op(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic sa, input logic sb);
    drive(1'b1, a, b, sa, sb);
    @(negedge clk);
    drive(1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    check({req, " valid not early"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, product, model(a, b, sa, sb));
    @(negedge clk);
    check({req, " single valid"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 product in reset", product, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", {31'd0, out_valid}, 32'd0);
    check("R1 product after release", product, 32'd0);
  endtask

  task automatic t_unsigned();
    one_op("R2 uu max", 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    one_op("R2 uu mid", 16'h8000, 16'h0003, 1'b0, 1'b0);
    one_op("R2 uu zero", 16'h1234, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_signed();
    one_op("R3 ss min*min", 16'h8000, 16'h8000, 1'b1, 1'b1);
    one_op("R3 ss neg*pos", 16'hFFFF, 16'h7FFF, 1'b1, 1'b1);
    one_op("R3 ss neg*neg", 16'hFFFE, 16'hFFFD, 1'b1, 1'b1);
  endtask

  task automatic t_mixed();
    one_op("R4 su", 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    one_op("R4 us", 16'h8000, 16'h8000, 1'b0, 1'b1);
    one_op("R4 su min", 16'h8000, 16'hFFFF, 1'b1, 1'b0);
    one_op("R5 timing", 16'h0102, 16'h0304, 1'b0, 1'b1);
  endtask

  task automatic t_stream();
    logic [15:0] av [8] = '{16'h8000, 16'hFFFF, 16'h7FFF, 16'h8000,
                            16'h0001, 16'hFFFF, 16'hABCD, 16'h8001};
    logic [15:0] bv [8] = '{16'hFFFF, 16'h8000, 16'h8000, 16'h7FFF,
                            16'hFFFF, 16'hFFFF, 16'h1234, 16'hFFFE};
    logic [31:0] exp [8];
    for (int i = 0; i < 8; i++) begin
      exp[i] = model(av[i], bv[i], i[0], i[1]);
      drive(1'b1, av[i], bv[i], i[0], i[1]);
      @(negedge clk);
      if (i >= 1) begin
        check("R6 stream valid", {31'd0, out_valid}, 32'd1);
        check("R6 stream product", product, exp[i-1]);
      end
    end
    drive(1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    check("R6 stream last valid", {31'd0, out_valid}, 32'd1);
    check("R6 stream last", product, exp[7]);
    @(negedge clk);
    check("R6 stream end", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] held;
    one_op("R7 setup", 16'h00FF, 16'h0101, 1'b0, 1'b0);
    held = model(16'h00FF, 16'h0101, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 16'h8000 + 16'(i), 16'hFFFF - 16'(i), i[0], i[1]);
      @(negedge clk);
      check("R7 hold product", product, held);
      check("R7 hold valid", {31'd0, out_valid}, 32'd0);
    end
    drive(1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R7 hold after idle", product, held);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_mixed();
    t_stream();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule